// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block orders two single-precision IEEE-754 values and records the outcome as a four-bit condition code in the top nibble of a 32-bit floating-point status word. A caller presents both operands, the current status word and a select between a quiet and a signaling compare, then pulses `start`. One clock later the registered status word carries the new condition code above the unchanged lower bits of the word that was presented, `done` pulses, and `invalid` reports an invalid-operation exception for the compare.

Zeros of either sign, subnormals, infinities and both kinds of NaN are classified before ordering. Any NaN operand makes the result unordered. The two compare flavours give the same condition code and differ only in which NaNs raise the invalid flag. The status register holds its value between compares and a synchronous reset clears it.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When the operands are equal, bits [31:28] of `stat_out` become 4'b0110.
- R2: When A is less than B, bits [31:28] become 4'b1000.
- R3: When A is greater than B, bits [31:28] become 4'b0010.
- R4: When either operand is a NaN (exponent all ones, fraction nonzero), bits [31:28] become 4'b0011.
- R5: On every compare, bits [27:0] of `stat_out` take the value of `stat_in[27:0]` sampled with `start`.
- R6: With `sig_cmp`=0, `invalid` is raised only when an operand is a signaling NaN (fraction bit 22 clear, fraction nonzero).
- R7: With `sig_cmp`=1, `invalid` is raised when either operand is any NaN; both flavours yield the same condition code.
- R8: +0 (0x00000000) and -0 (0x80000000) compare equal to each other and to themselves.
- R9: Ordered values follow sign and magnitude: a negative value is below a positive one, and between two negatives the larger magnitude is the smaller value; subnormals and infinities order by their encoding.
- R10: `stat_out` updates at the clock edge that samples `start`; `done` is high for exactly the cycle after each sampled `start`, and `invalid` is only high together with `done`. Without `start`, `stat_out` holds.
- R11: A synchronous reset clears `stat_out` to zero and holds `done` and `invalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Compare request, sampled on the rising edge |
| sig_cmp | input | 1 | 1 selects the signaling compare, 0 the quiet one |
| op_a | input | 32 | Operand A, single precision |
| op_b | input | 32 | Operand B, single precision |
| stat_in | input | 32 | Current status word whose low 28 bits are kept |
| stat_out | output | 32 | Registered status word with the condition code on top |
| done | output | 1 | One-cycle pulse after a compare |
| invalid | output | 1 | Invalid-operation flag, valid with `done` |

## Verification
The hardest situation to reach from the ports is a quiet compare where exactly one operand is a signaling NaN whose fraction differs from a quiet NaN only in bit 22, or where a NaN sits next to an infinity that shares its exponent; uniformly random operands almost never land there. The stimulus therefore draws most operands from a pool of boundary encodings (both zeros, smallest and largest subnormals, smallest normal, largest finite value, both infinities, quiet and signaling NaNs with minimal and full payloads) mixed with random words, flips sign bits at random, runs both compare flavours on the same pairs, and issues back-to-back starts as well as idle gaps while the presented status word keeps changing.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_LT = 2'd1,
      REL_GT = 2'd2,
      REL_UN = 2'd3
   } fcmp_rel_e;

   localparam int unsigned CC_W = 4;

   localparam logic [CC_W-1:0] CC_EQUAL   = 4'b0110;
   localparam logic [CC_W-1:0] CC_LESS    = 4'b1000;
   localparam logic [CC_W-1:0] CC_GREATER = 4'b0010;
   localparam logic [CC_W-1:0] CC_UNORD   = 4'b0011;

   function automatic logic [CC_W-1:0] rel_to_cc(input fcmp_rel_e rel);
      logic [CC_W-1:0] cc;
      unique case (rel)
         REL_EQ:  cc = CC_EQUAL;
         REL_LT:  cc = CC_LESS;
         REL_GT:  cc = CC_GREATER;
         default: cc = CC_UNORD;
      endcase
      return cc;
   endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned FP_W  = 1 + EXP_W + MAN_W,
   localparam int unsigned MAG_W = EXP_W + MAN_W
) (
   input  logic [FP_W-1:0]  opnd,
   output logic             sgn,
   output logic             is_zero,
   output logic             is_nan,
   output logic             is_snan,
   output logic [MAG_W-1:0] mag
);

   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] frac;
   logic             exp_max;
   logic             frac_nz;

   assign sgn  = opnd[FP_W-1];
   assign expo = opnd[FP_W-2 -: EXP_W];
   assign frac = opnd[MAN_W-1:0];
   assign mag  = opnd[MAG_W-1:0];

   assign exp_max = &expo;
   assign frac_nz = |frac;

   assign is_zero = ~(|mag);
   assign is_nan  = exp_max & frac_nz;
   assign is_snan = is_nan & ~frac[MAN_W-1];

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
   import fcmp_pkg::*;
#(
   parameter int unsigned EXP_W     = 8,
   parameter int unsigned MAN_W     = 23,
   parameter bit          SPLIT_MAG = 1'b1,
   localparam int unsigned MAG_W    = EXP_W + MAN_W
) (
   input  logic             a_sgn,
   input  logic             a_zero,
   input  logic             a_nan,
   input  logic [MAG_W-1:0] a_mag,
   input  logic             b_sgn,
   input  logic             b_zero,
   input  logic             b_nan,
   input  logic [MAG_W-1:0] b_mag,
   output fcmp_rel_e        rel
);

   logic mag_gt;
   logic mag_eq;

   generate
      if (SPLIT_MAG) begin : g_split
         logic [EXP_W-1:0] ea, eb;
         logic [MAN_W-1:0] ma, mb;
         logic             exp_gt, exp_eq, man_gt, man_eq;
         assign ea     = a_mag[MAG_W-1 -: EXP_W];
         assign eb     = b_mag[MAG_W-1 -: EXP_W];
         assign ma     = a_mag[MAN_W-1:0];
         assign mb     = b_mag[MAN_W-1:0];
         assign exp_gt = ea > eb;
         assign exp_eq = ea == eb;
         assign man_gt = ma > mb;
         assign man_eq = ma == mb;
         assign mag_gt = exp_gt | (exp_eq & man_gt);
         assign mag_eq = exp_eq & man_eq;
      end else begin : g_flat
         assign mag_gt = a_mag > b_mag;
         assign mag_eq = a_mag == b_mag;
      end
   endgenerate

   always_comb begin
      if (a_nan | b_nan) begin
         rel = REL_UN;
      end else if (a_zero & b_zero) begin
         rel = REL_EQ;
      end else if (a_sgn != b_sgn) begin
         rel = a_sgn ? REL_LT : REL_GT;
      end else if (mag_eq) begin
         rel = REL_EQ;
      end else if (mag_gt ^ a_sgn) begin
         rel = REL_GT;
      end else begin
         rel = REL_LT;
      end
   end

endmodule

// File: rtl/fcmp_encode.sv
module fcmp_encode
   import fcmp_pkg::*;
(
   input  fcmp_rel_e       rel,
   input  logic            sig_cmp,
   input  logic            a_nan,
   input  logic            a_snan,
   input  logic            b_nan,
   input  logic            b_snan,
   output logic [CC_W-1:0] cc,
   output logic            inv
);

   logic any_nan;
   logic any_snan;

   assign any_nan  = a_nan | b_nan;
   assign any_snan = a_snan | b_snan;

   assign cc  = rel_to_cc(rel);
   assign inv = sig_cmp ? any_nan : any_snan;

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
   import fcmp_pkg::*;
#(
   parameter int unsigned EXP_W     = 8,
   parameter int unsigned MAN_W     = 23,
   parameter int unsigned STAT_W    = 32,
   parameter bit          SPLIT_MAG = 1'b1,
   localparam int unsigned FP_W     = 1 + EXP_W + MAN_W,
   localparam int unsigned MAG_W    = EXP_W + MAN_W,
   localparam int unsigned KEEP_W   = STAT_W - CC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              sig_cmp,
   input  logic [FP_W-1:0]   op_a,
   input  logic [FP_W-1:0]   op_b,
   input  logic [STAT_W-1:0] stat_in,
   output logic [STAT_W-1:0] stat_out,
   output logic              done,
   output logic              invalid
);

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fcmp_flag_unit: EXP_W must be at least 2");
      end
      if (MAN_W < 2) begin : g_bad_man
         $error("fcmp_flag_unit: MAN_W must be at least 2");
      end
      if (STAT_W <= CC_W) begin : g_bad_stat
         $error("fcmp_flag_unit: STAT_W must exceed the condition code width");
      end
   endgenerate

   logic             cls_sgn  [2];
   logic             cls_zero [2];
   logic             cls_nan  [2];
   logic             cls_snan [2];
   logic [MAG_W-1:0] cls_mag  [2];
   logic [FP_W-1:0]  opnd     [2];

   assign opnd[0] = op_a;
   assign opnd[1] = op_b;

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_cls
         fcmp_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
         ) u_cls (
            .opnd    (opnd[gi]),
            .sgn     (cls_sgn[gi]),
            .is_zero (cls_zero[gi]),
            .is_nan  (cls_nan[gi]),
            .is_snan (cls_snan[gi]),
            .mag     (cls_mag[gi])
         );
      end
   endgenerate

   fcmp_rel_e       rel;
   logic [CC_W-1:0] cc_nxt;
   logic            inv_nxt;

   fcmp_order #(
      .EXP_W     (EXP_W),
      .MAN_W     (MAN_W),
      .SPLIT_MAG (SPLIT_MAG)
   ) u_order (
      .a_sgn  (cls_sgn[0]),
      .a_zero (cls_zero[0]),
      .a_nan  (cls_nan[0]),
      .a_mag  (cls_mag[0]),
      .b_sgn  (cls_sgn[1]),
      .b_zero (cls_zero[1]),
      .b_nan  (cls_nan[1]),
      .b_mag  (cls_mag[1]),
      .rel    (rel)
   );

   fcmp_encode u_enc (
      .rel     (rel),
      .sig_cmp (sig_cmp),
      .a_nan   (cls_nan[0]),
      .a_snan  (cls_snan[0]),
      .b_nan   (cls_nan[1]),
      .b_snan  (cls_snan[1]),
      .cc      (cc_nxt),
      .inv     (inv_nxt)
   );

   logic [STAT_W-1:0] stat_q;
   logic              done_q;
   logic              inv_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q <= '0;
         done_q <= 1'b0;
         inv_q  <= 1'b0;
      end else begin
         done_q <= start;
         inv_q  <= start & inv_nxt;
         if (start) begin
            stat_q <= {cc_nxt, stat_in[KEEP_W-1:0]};
         end
      end
   end

   assign stat_out = stat_q;
   assign done     = done_q;
   assign invalid  = inv_q;

endmodule

// File: rtl/fcmp_flag_chk.sv
module fcmp_flag_chk #(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned MAN_W  = 23,
   parameter int unsigned STAT_W = 32,
   localparam int unsigned FP_W  = 1 + EXP_W + MAN_W,
   localparam int unsigned MAG_W = EXP_W + MAN_W,
   localparam int unsigned KEEP_W = STAT_W - 4
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              sig_cmp,
   input logic [FP_W-1:0]   op_a,
   input logic [FP_W-1:0]   op_b,
   input logic [STAT_W-1:0] stat_in,
   input logic [STAT_W-1:0] stat_out,
   input logic              done,
   input logic              invalid
);

   logic a_nan, b_nan, both_zero;
   logic [3:0] cc_now;

   assign a_nan     = (&op_a[FP_W-2 -: EXP_W]) & (|op_a[MAN_W-1:0]);
   assign b_nan     = (&op_b[FP_W-2 -: EXP_W]) & (|op_b[MAN_W-1:0]);
   assign both_zero = ~(|op_a[MAG_W-1:0]) & ~(|op_b[MAG_W-1:0]);
   assign cc_now    = stat_out[STAT_W-1 -: 4];

   // R11
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (stat_out == '0 && !done && !invalid));

   // R10
   done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> done);

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      !start |=> !done);

   // R10
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !start |=> $stable(stat_out));

   // R10
   inv_with_done_chk: assert property (@(posedge clk) disable iff (rst)
      invalid |-> done);

   // R5
   keep_low_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> stat_out[KEEP_W-1:0] == $past(stat_in[KEEP_W-1:0]));

   // R4
   unord_code_chk: assert property (@(posedge clk) disable iff (rst)
      (start && (a_nan || b_nan)) |=> cc_now == 4'b0011);

   // R7
   sig_nan_inv_chk: assert property (@(posedge clk) disable iff (rst)
      (start && sig_cmp && (a_nan || b_nan)) |=> invalid);

   // R6
   no_inv_ordered_chk: assert property (@(posedge clk) disable iff (rst)
      (start && !a_nan && !b_nan) |=> !invalid);

   // R8
   zeros_equal_chk: assert property (@(posedge clk) disable iff (rst)
      (start && both_zero) |=> cc_now == 4'b0110);

   // R1
   legal_code_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (cc_now == 4'b0110 || cc_now == 4'b1000 ||
                cc_now == 4'b0010 || cc_now == 4'b0011));

endmodule

bind fcmp_flag_unit fcmp_flag_chk #(
   .EXP_W  (EXP_W),
   .MAN_W  (MAN_W),
   .STAT_W (STAT_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .sig_cmp  (sig_cmp),
   .op_a     (op_a),
   .op_b     (op_b),
   .stat_in  (stat_in),
   .stat_out (stat_out),
   .done     (done),
   .invalid  (invalid)
);

// File: tb/sim_fcmp_flag_unit.sv
module sim_fcmp_flag_unit;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        sig_cmp = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [31:0] stat_in = '0;
   logic [31:0] stat_out;
   logic        done;
   logic        invalid;

   int total = 0;
   int bad   = 0;
   bit chk_en = 1'b0;
   string cur_tag = "R1";

   // reference model state
   logic [31:0] m_stat = '0;
   logic        m_done = 1'b0;
   logic        m_inv  = 1'b0;
   string       m_tag  = "R1";
   string       m_itag = "R6";

   fcmp_flag_unit u0 (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .sig_cmp  (sig_cmp),
      .op_a     (op_a),
      .op_b     (op_b),
      .stat_in  (stat_in),
      .stat_out (stat_out),
      .done     (done),
      .invalid  (invalid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic bit is_nan(input logic [31:0] v);
      return (v[30:23] == 8'hFF) && (v[22:0] != 0);
   endfunction

   function automatic bit is_snan(input logic [31:0] v);
      return is_nan(v) && !v[22];
   endfunction

   function automatic longint key(input logic [31:0] v);
      longint m;
      m = longint'(v[30:0]);
      return v[31] ? -m : m;
   endfunction

   function automatic logic [3:0] ref_cc(input logic [31:0] a, input logic [31:0] b);
      longint ka, kb;
      if (is_nan(a) || is_nan(b)) return 4'b0011;
      ka = key(a);
      kb = key(b);
      if (ka == kb) return 4'b0110;
      if (ka < kb)  return 4'b1000;
      return 4'b0010;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         m_stat <= '0;
         m_done <= 1'b0;
         m_inv  <= 1'b0;
      end else begin
         m_done <= start;
         m_inv  <= start && (sig_cmp ? (is_nan(op_a) || is_nan(op_b))
                                     : (is_snan(op_a) || is_snan(op_b)));
         if (start) begin
            m_stat <= {ref_cc(op_a, op_b), stat_in[27:0]};
            m_tag  <= cur_tag;
            m_itag <= sig_cmp ? "R7" : "R6";
         end
      end
   end

   always @(negedge clk) begin
      if (chk_en) begin
         chk(m_tag, {28'd0, stat_out[31:28]}, {28'd0, m_stat[31:28]});
         chk("R5", {4'd0, stat_out[27:0]}, {4'd0, m_stat[27:0]});
         chk("R10", {31'd0, done}, {31'd0, m_done});
         chk(m_itag, {31'd0, invalid}, {31'd0, m_inv});
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic op(input logic [31:0] a, input logic [31:0] b,
                     input logic s, input string tag);
      op_a    = a;
      op_b    = b;
      sig_cmp = s;
      stat_in = $urandom;
      cur_tag = tag;
      start   = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      start = 1'b0;
      for (int i = 0; i < n; i++) begin
         stat_in = $urandom;
         op_a    = $urandom;
         op_b    = $urandom;
         @(negedge clk);
      end
   endtask

   function automatic logic [31:0] pick();
      logic [31:0] v;
      case ($urandom % 16)
         0:  v = 32'h0000_0000;
         1:  v = 32'h0000_0001;
         2:  v = 32'h007F_FFFF;
         3:  v = 32'h0080_0000;
         4:  v = 32'h7F7F_FFFF;
         5:  v = 32'h7F80_0000;
         6:  v = 32'h7FC0_0000;
         7:  v = 32'h7F80_0001;
         8:  v = 32'h7FBF_FFFF;
         9:  v = 32'h7FFF_FFFF;
         10: v = 32'h3F80_0000;
         11: v = 32'h3F80_0001;
         default: v = $urandom;
      endcase
      if ($urandom % 2) v[31] = ~v[31];
      return v;
   endfunction

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R11: reset state
      chk("R11", stat_out, 32'h0);
      chk("R11", {31'd0, done}, 32'h0);
      rst = 1'b0;
      chk_en = 1'b1;
      @(negedge clk);

      // R8: signed zeros
      op(32'h0000_0000, 32'h8000_0000, 1'b0, "R8");
      op(32'h8000_0000, 32'h0000_0000, 1'b1, "R8");
      op(32'h8000_0000, 32'h8000_0000, 1'b0, "R8");
      idle(1);
      // R1 equal
      op(32'h3F80_0000, 32'h3F80_0000, 1'b0, "R1");
      op(32'h7F80_0000, 32'h7F80_0000, 1'b1, "R1");
      // R2 / R3
      op(32'h3F80_0000, 32'h4000_0000, 1'b0, "R2");
      op(32'h4000_0000, 32'h3F80_0000, 1'b0, "R3");
      op(32'h3F80_0000, 32'h3F80_0001, 1'b1, "R2");
      // R9 negatives, subnormals, infinities
      op(32'hBF80_0000, 32'hC000_0000, 1'b0, "R9");
      op(32'hC000_0000, 32'hBF80_0000, 1'b0, "R9");
      op(32'h8000_0001, 32'h0000_0000, 1'b0, "R9");
      op(32'h0000_0001, 32'h8000_0000, 1'b0, "R9");
      op(32'h007F_FFFF, 32'h0080_0000, 1'b0, "R9");
      op(32'h7F7F_FFFF, 32'h7F80_0000, 1'b0, "R9");
      op(32'hFF80_0000, 32'hFF7F_FFFF, 1'b0, "R9");
      op(32'hBF80_0000, 32'h3F80_0000, 1'b0, "R9");
      idle(2);
      // R4 / R6 / R7 NaNs in both flavours
      op(32'h7FC0_0000, 32'h3F80_0000, 1'b0, "R4");
      op(32'h7FC0_0000, 32'h3F80_0000, 1'b1, "R4");
      op(32'h3F80_0000, 32'h7F80_0001, 1'b0, "R6");
      op(32'h3F80_0000, 32'hFFBF_FFFF, 1'b1, "R7");
      op(32'h7F80_0000, 32'hFFC0_0001, 1'b0, "R6");
      op(32'hFFC0_0000, 32'h7FC0_0000, 1'b1, "R7");
      idle(3);
      // R10 hold across idle gap with changing stat_in (checked per cycle)
      op(32'h4000_0000, 32'h3F80_0000, 1'b0, "R10");
      idle(4);
      // R11 reset mid-run while start is high
      op_a = 32'h7F80_0001; op_b = 32'h0; sig_cmp = 1'b1; start = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      chk("R11", stat_out, 32'h0);
      chk("R11", {31'd0, invalid}, 32'h0);
      rst = 1'b0;
      start = 1'b0;
      @(negedge clk);
      // random mix from boundary pool
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a, b;
         a = pick();
         b = ($urandom % 5 == 0) ? a : pick();
         op(a, b, 1'(($urandom) % 2), "R9");
         if ($urandom % 4 == 0) idle(1 + ($urandom % 3));
      end
      idle(3);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule